// File: doc/BRIEF.md
# Background Memory Scrub CRC Checker

This block checks, while the design is running, that a protected memory still holds the contents it was loaded with. A sequencer reads the memory through a read port, one word per cycle, starting at address 0. It feeds each word into a 32-bit CRC engine. The whole memory is covered by one reference CRC, not one value per region. At the end of each full pass, the computed value is XORed with a reference value that a host has written into a storage register. The result is kept in a signature register.

A signature of zero means the memory matches the reference. Any non-zero signature drives the error output high. While the enable input stays high, passes repeat back to back. Lowering enable during a scan abandons the pass and leaves the previous result in place. The memory array itself is outside the block. So is locating or correcting a faulty bit.

Top module: `scrub_crc_checker`

## Requirements
- R1: After reset, `signature` is zero, `crc_error` is low and `rd_en` is low.
- R2: The CRC has these properties:
  - Polynomial 0x04C11DB7, processed MSB-first, with no reflection and no final XOR.
  - Each pass starts from an all-ones seed.
  - Each word is shifted in from its most significant bit down.
  - Words are taken from address 0 up to the last address (2**ADDR_W words).
- R3: At the end of a pass, `signature` becomes the computed CRC XOR the stored reference. With RD_LAT=1 and ADDR_W=4, it is visible after the second rising edge following the edge that accepts the read of address 15.
- R4: `crc_error` is high exactly when `signature` is non-zero.
- R5: `signature` and `crc_error` change only at the end of a pass or on a reference load. They hold steady throughout the following pass.
- R6: A pulse on `ref_we` does three things:
  - It stores `ref_wdata` as the reference for later comparisons.
  - It clears `signature` and `crc_error` at the same edge.
  - It overrides a comparison result landing on that same edge.
- R7: During a scan, `rd_en` is high and the address advances by one on each cycle in which `mem_ready` is high. While `mem_ready` is low, `rd_en` is low and `rd_addr` holds.
- R8: With `scan_en` held high, a new pass starts right after the result update. In the cycle after that update edge, `rd_addr` is 0 and `rd_en` follows `mem_ready`.
- R9: Lowering `scan_en` during a scan stops reads from the next cycle and discards the pass. `signature` and `crc_error` keep their values. No reads occur while `scan_en` is low.
- R10: `rd_data` is taken RD_LAT cycles (0 or 1) after the cycle in which `rd_en` was high for that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Enables background scanning; passes repeat while high |
| mem_ready | input | 1 | Memory can accept a read this cycle |
| rd_en | output | 1 | Read request to the protected memory |
| rd_addr | output | ADDR_W | Word address of the read |
| rd_data | input | DATA_W | Read data, RD_LAT cycles after the request |
| ref_we | input | 1 | Host write strobe for the reference CRC |
| ref_wdata | input | CRC_W | Reference CRC value to store |
| signature | output | CRC_W | Computed CRC XOR reference from the last full pass |
| crc_error | output | 1 | High while the signature is non-zero |

## Verification
Embedded assertions check the following on every cycle:
- The address stepping and holding rules under `mem_ready`.
- Restart at address 0 after an update while enabled.
- Abort to idle when enable drops mid-scan.
- The agreement of `crc_error` with a non-zero signature.
- That the signature does not move outside an update or a reference load.
- The clearing effect of a reference load.

The correctness of the CRC value, the exact cycle at which the result appears, and the precedence of a load over a simultaneous result can only be shown by the bench scenarios. These compare against an independent CRC of the bench's memory, both with stalled and with uninterrupted reads. The bench scenarios also show that an aborted pass leaves the old result untouched.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_CMP  = 2'd2,
      ST_UPD  = 2'd3
   } scrub_state_e;

endpackage

// File: rtl/scrub_seq.sv
module scrub_seq
   import scrub_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_en,
   input  logic              mem_ready,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              seed_ld,
   output logic              upd_now
);

   localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

   scrub_state_e      state_q, state_d;
   logic [ADDR_W-1:0] addr_q;

   assign rd_en   = (state_q == ST_SCAN) && scan_en && mem_ready;
   assign seed_ld = scan_en && ((state_q == ST_IDLE) || (state_q == ST_UPD));
   assign upd_now = (state_q == ST_UPD);
   assign rd_addr = addr_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (scan_en) state_d = ST_SCAN;
         ST_SCAN: begin
            if (!scan_en)
               state_d = ST_IDLE;
            else if (rd_en && (addr_q == LAST_ADDR))
               state_d = ST_CMP;
         end
         ST_CMP:  state_d = ST_UPD;
         ST_UPD:  state_d = scan_en ? ST_SCAN : ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
      end else begin
         state_q <= state_d;
         if (seed_ld)
            addr_q <= '0;
         else if (rd_en)
            addr_q <= addr_q + 1'b1;
      end
   end

   // R7: the address steps by one after every accepted read
   assert_addr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr_q != LAST_ADDR)) |=> (addr_q == $past(addr_q) + 1'b1));

   // R7: a stalled scan keeps its address
   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SCAN) && !mem_ready) |=> $stable(addr_q));

   // R8: an enabled update restarts the walk at address zero
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_UPD) && scan_en) |=> ((state_q == ST_SCAN) && (addr_q == '0)));

   // R9: dropping enable mid-scan returns to idle
   assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SCAN) && !scan_en) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/scrub_crc_engine.sv
module scrub_crc_engine #(
   parameter int              CRC_W  = 32,
   parameter int              DATA_W = 32,
   parameter logic [CRC_W-1:0] POLY  = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] SEED  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seed_ld,
   input  logic              din_vld,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc_q
);

   logic [CRC_W-1:0] crc_d;

   always_comb begin
      logic [CRC_W-1:0] c;
      logic             fb;
      c = crc_q;
      for (int i = DATA_W - 1; i >= 0; i--) begin
         fb = c[CRC_W-1] ^ din[i];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      crc_d = c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc_q <= SEED;
      else if (seed_ld)
         crc_q <= SEED;
      else if (din_vld)
         crc_q <= crc_d;
   end

   // R2: a pass always begins from the seed value
   assert_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seed_ld |=> (crc_q == SEED));

endmodule

// File: rtl/scrub_sig.sv
module scrub_sig #(
   parameter int CRC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_we,
   input  logic [CRC_W-1:0] ref_wdata,
   input  logic             upd_now,
   input  logic [CRC_W-1:0] crc_val,
   output logic [CRC_W-1:0] sig_q,
   output logic             err_q
);

   logic [CRC_W-1:0] ref_q;
   logic [CRC_W-1:0] diff;

   assign diff = crc_val ^ ref_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         sig_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (ref_we) begin
            ref_q <= ref_wdata;
            sig_q <= '0;
            err_q <= 1'b0;
         end else if (upd_now) begin
            sig_q <= diff;
            err_q <= |diff;
         end
      end
   end

   // R4: the error flag agrees with the held signature
   assert_err_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      err_q == (sig_q != '0));

   // R5: the signature moves only on an update or a load
   assert_sig_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_now && !ref_we) |=> ($stable(sig_q) && $stable(err_q)));

   // R6: a load clears the result
   assert_load_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ref_we |=> ((sig_q == '0) && !err_q));

endmodule

// File: rtl/scrub_crc_checker.sv
module scrub_crc_checker #(
   parameter int               ADDR_W = 4,
   parameter int               DATA_W = 32,
   parameter int               CRC_W  = 32,
   parameter int               RD_LAT = 1,
   parameter logic [CRC_W-1:0] POLY   = 32'h04C1_1DB7,
   parameter logic [CRC_W-1:0] SEED   = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_en,
   input  logic              mem_ready,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              ref_we,
   input  logic [CRC_W-1:0]  ref_wdata,
   output logic [CRC_W-1:0]  signature,
   output logic              crc_error
);

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
      $error("scrub_crc_checker: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("scrub_crc_checker: DATA_W must be positive");
   end
   if (CRC_W < 2) begin : g_bad_crc
      $error("scrub_crc_checker: CRC_W must be at least 2");
   end
   if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
      $error("scrub_crc_checker: RD_LAT must be 0 or 1");
   end

   logic seed_ld;
   logic upd_now;
   logic word_vld;
   logic [CRC_W-1:0] crc_val;

   scrub_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .scan_en   (scan_en),
      .mem_ready (mem_ready),
      .rd_en     (rd_en),
      .rd_addr   (rd_addr),
      .seed_ld   (seed_ld),
      .upd_now   (upd_now)
   );

   if (RD_LAT == 1) begin : g_lat1
      logic vld_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) vld_q <= 1'b0;
         else        vld_q <= rd_en;
      end
      assign word_vld = vld_q;
   end else begin : g_lat0
      assign word_vld = rd_en;
   end

   scrub_crc_engine #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W),
      .POLY   (POLY),
      .SEED   (SEED)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .seed_ld (seed_ld),
      .din_vld (word_vld),
      .din     (rd_data),
      .crc_q   (crc_val)
   );

   scrub_sig #(.CRC_W(CRC_W)) u_sig (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_we    (ref_we),
      .ref_wdata (ref_wdata),
      .upd_now   (upd_now),
      .crc_val   (crc_val),
      .sig_q     (signature),
      .err_q     (crc_error)
   );

   // R9: with enable low on the previous edge no read is issued
   assert_no_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(scan_en) |-> !rd_en);

endmodule

// File: tb/sim_scrub_crc_checker.sv
module sim_scrub_crc_checker;

   localparam int AW = 4;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_en = 1'b0;
   logic          mem_ready = 1'b1;
   logic          rd_en;
   logic [AW-1:0] rd_addr;
   logic [31:0]   rd_data = '0;
   logic          ref_we = 1'b0;
   logic [31:0]   ref_wdata = '0;
   logic [31:0]   signature;
   logic          crc_error;

   logic [31:0] mem [NW];
   int n_run = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

   scrub_crc_checker u0 (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mem_ready(mem_ready),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .ref_we(ref_we), .ref_wdata(ref_wdata),
      .signature(signature), .crc_error(crc_error)
   );

   // tag in [31:0]-exp
   localparam logic [63:0] VEC [6] = '{
      {32'h0000_0000, 32'h0000_0000},
      {32'h1234_5678, 32'h0000_0001},
      {32'hDEAD_BEEF, 32'h8000_0000},
      {32'hFFFF_FFFF, 32'h0000_0000},
      {32'h0F0F_0F0F, 32'hFFFF_FFFF},
      {32'hA5A5_0001, 32'h0000_0000}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] crc_mem();
      logic [31:0] c = 32'hFFFF_FFFF;
      logic fb;
      for (int w = 0; w < NW; w++)
         for (int b = 31; b >= 0; b--) begin
            fb = c[31] ^ mem[w][b];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      return c;
   endfunction

   task automatic fill(input logic [31:0] s);
      for (int i = 0; i < NW; i++) mem[i] = s + i * 32'h9E37_79B9;
   endtask

   task automatic load_ref(input logic [31:0] v);
      @(negedge clk); ref_we = 1'b1; ref_wdata = v;
      @(negedge clk); ref_we = 1'b0;
   endtask

   task automatic go_idle();
      @(negedge clk); scan_en = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // waits for the last read, optionally stalling; ends at the negedge after the update
   task automatic run_pass(input bit stall, output bit stall_ok);
      bit prev_rdy = 1'b1;
      logic [AW-1:0] prev_addr = '0;
      int k = 0;
      stall_ok = 1'b1;
      forever begin
         @(negedge clk);
         if (!prev_rdy && (rd_en || rd_addr != prev_addr)) stall_ok = 1'b0;
         if (rd_en && rd_addr == AW'(NW - 1)) break;
         prev_addr = rd_addr;
         if (stall) mem_ready = (k % 3) != 2;
         prev_rdy = mem_ready;
         k++;
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      mem_ready = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] ref_v;
      bit ok;
      for (int i = 0; i < NW; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 signature", signature, 32'h0);
      chk("R1 crc_error", {31'b0, crc_error}, 32'h0);
      chk("R1 rd_en", {31'b0, rd_en}, 32'h0);

      // vector walk: R2 R3 R4 R6
      for (int v = 0; v < 6; v++) begin
         go_idle();
         fill(VEC[v][63:32]);
         load_ref(crc_mem() ^ VEC[v][31:0]);
         chk("R6 load clears sig", signature, 32'h0);
         scan_en = 1'b1;
         run_pass(1'b0, ok);
         chk("R2 R3 signature", signature, VEC[v][31:0]);
         chk("R4 crc_error", {31'b0, crc_error}, {31'b0, VEC[v][31:0] != 0});
      end

      // R8 R5: continuous passes
      go_idle();
      fill(32'h3C3C_1111);
      ref_v = crc_mem() ^ 32'h5;
      load_ref(ref_v);
      scan_en = 1'b1;
      run_pass(1'b0, ok);
      chk("R3 first pass", signature, 32'h5);
      chk("R8 restart addr", {28'b0, rd_addr}, 32'h0);
      chk("R8 restart rd_en", {31'b0, rd_en}, 32'h1);
      while (!(rd_en && rd_addr == AW'(8))) @(negedge clk);
      chk("R5 hold mid-pass", signature, 32'h5);
      chk("R5 err hold mid-pass", {31'b0, crc_error}, 32'h1);
      run_pass(1'b0, ok);
      chk("R8 repeated pass", signature, 32'h5);
      mem[5] = mem[5] ^ 32'h0000_0400;
      run_pass(1'b0, ok);
      chk("R2 corrupted word", signature, crc_mem() ^ ref_v);

      // R7 R10: stalled reads
      go_idle();
      fill(32'h7777_0000);
      load_ref(crc_mem());
      scan_en = 1'b1;
      run_pass(1'b1, ok);
      chk("R7 stall holds rd_en and addr", {31'b0, ok}, 32'h1);
      chk("R10 stalled pass matches", signature, 32'h0);
      chk("R4 stalled no error", {31'b0, crc_error}, 32'h0);

      // R9: abort mid-scan
      go_idle();
      fill(32'h0BAD_0000);
      load_ref(crc_mem() ^ 32'h99);
      scan_en = 1'b1;
      while (!(rd_en && rd_addr == AW'(6))) @(negedge clk);
      scan_en = 1'b0;
      ok = 1'b1;
      repeat (20) begin
         @(negedge clk);
         if (rd_en) ok = 1'b0;
      end
      chk("R9 no reads after abort", {31'b0, ok}, 32'h1);
      chk("R9 signature kept", signature, 32'h0);
      chk("R9 error kept", {31'b0, crc_error}, 32'h0);

      // R6: load on the update edge wins, new reference used next pass
      fill(32'h5151_2222);
      load_ref(crc_mem() ^ 32'hF0);
      scan_en = 1'b1;
      while (!(rd_en && rd_addr == AW'(NW - 1))) @(negedge clk);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      ref_we = 1'b1; ref_wdata = crc_mem() ^ 32'h10;
      @(posedge clk);
      @(negedge clk);
      ref_we = 1'b0;
      chk("R6 load beats update sig", signature, 32'h0);
      chk("R6 load beats update err", {31'b0, crc_error}, 32'h0);
      run_pass(1'b0, ok);
      chk("R6 new reference used", signature, 32'h10);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

endmodule